// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard control for a five-stage in-order pipeline. The stages are fetch, decode with register read, execute, memory and writeback. Branches resolve in decode on their own comparator and have one delay slot. The block looks at the register fields, write enables and load flags of the instructions now in decode, execute, memory and writeback. From these it produces three things:

- operand-source selects for the execute stage;
- operand-source selects for the decode-stage branch comparator;
- a single freeze condition. This condition holds the PC and the fetch/decode register, and places a bubble into the decode/execute register.

The block also performs the branch comparison itself. It takes the register-file read values and the memory-stage ALU result, and it reports whether the branch in decode is taken. The surrounding datapath uses that flag to select the next PC. The register file writes before it reads in the same cycle. Because of this, a producer three instructions ahead never needs a bypass.

A load followed at once by a consumer of its result costs exactly one bubble. A branch that needs a result not yet available waits in decode until the value can reach the comparator. The instruction that follows a branch is never cancelled.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: With no register write in flight, every forwarding select is 0, and the stall, bubble and taken outputs are low.
- R2: An execute-stage operand whose register matches the nonzero destination of a non-load writer in the memory stage gets select code 2'b10 (memory-stage value).
- R3: An execute-stage operand whose register matches only the nonzero destination of a writer in writeback gets code 2'b01. Code 2'b11 never appears. Code 2'b00 means the register-file value.
- R4: When both the memory stage and the writeback stage match an execute operand, code 2'b10 wins.
- R5: Register 0 is never forwarded and never causes a stall.
- R6: A load in execute whose destination is read by the instruction in decode raises stall and bubble for exactly one cycle. The consumer then reaches execute with code 2'b01, so the program takes one extra cycle.
- R7: A load followed by one unrelated instruction and then a consumer causes no stall. The consumer gets code 2'b01.
- R8: A branch in decode that reads the destination of a non-load writer in execute stalls for one cycle. It then resolves with decode select 1 (memory-stage ALU value).
- R9: A branch that reads the destination of a load stalls for two cycles while the load is in execute and in memory. It then resolves from the register file (decode select 0).
- R10: The taken output is high for an equal-compare branch when its operands are equal, and for a not-equal branch when they differ. It is only high in a cycle without a stall.
- R11: The instruction right after a branch enters execute in the cycle after the branch, whether or not the branch is taken.
- R12: A branch operand written by the instruction now in writeback uses decode select 0 and causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by checks only) |
| rst_n | input | 1 | Active-low reset (used by checks only) |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_branch_ne | input | 1 | Branch condition is not-equal (else equal) |
| id_rs_data | input | DW | Register-file value for id_rs |
| id_rt_data | input | DW | Register-file value for id_rt |
| ex_rs | input | AW | First source register of the execute instruction |
| ex_rt | input | AW | Second source register of the execute instruction |
| ex_use_rs | input | 1 | Execute instruction reads ex_rs |
| ex_use_rt | input | 1 | Execute instruction reads ex_rt |
| ex_rd | input | AW | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_alu_data | input | DW | ALU result held in the memory stage |
| wb_rd | input | AW | Destination of the writeback instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| ex_fwd_a | output | 2 | Source select for execute operand A |
| ex_fwd_b | output | 2 | Source select for execute operand B |
| id_fwd_a | output | 1 | Comparator operand A from the memory stage |
| id_fwd_b | output | 1 | Comparator operand B from the memory stage |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode/execute register |
| br_taken | output | 1 | Branch in decode is taken |

## Verification
The bench runs short programs through a model of the pipeline that obeys stall and bubble, and it counts the bubbles.

It covers several corner cases, each of which a specific design error would break:
- Two writers of the same register in flight. Wrong priority would feed a stale value, shown as code 01 instead of 10.
- A load feeding the very next instruction. A missing interlock gives zero stalls, and a sticky one gives two.
- A branch behind an ALU result or a load. Miscounting the decode-stage wait would change the stall total, or resolve the branch while stalled.
- Register 0 producers and a producer already in writeback. A design that bypasses these would stall or switch the comparator source without cause.

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_use_rs,
  input  logic          id_use_rt,
  input  logic          id_branch,
  input  logic          id_branch_ne,
  input  logic [DW-1:0] id_rs_data,
  input  logic [DW-1:0] id_rt_data,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic          ex_use_rs,
  input  logic          ex_use_rt,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic [DW-1:0] mem_alu_data,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic          id_fwd_a,
  output logic          id_fwd_b,
  output logic          stall,
  output logic          bubble,
  output logic          br_taken
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic mem_alu_ok, mem_ld_ok, wb_ok, ex_wr_ok;
  assign mem_alu_ok = mem_we && !mem_load && (mem_rd != '0);
  assign mem_ld_ok  = mem_we && mem_load && (mem_rd != '0);
  assign wb_ok      = wb_we && (wb_rd != '0);
  assign ex_wr_ok   = ex_we && (ex_rd != '0);

  function automatic logic [1:0] pick_ex(input logic use_r, input logic [AW-1:0] r,
                                         input logic m_ok, input logic [AW-1:0] m_rd,
                                         input logic w_ok, input logic [AW-1:0] w_rd);
    if (use_r && m_ok && (m_rd == r))      pick_ex = SEL_MEM;
    else if (use_r && w_ok && (w_rd == r)) pick_ex = SEL_WB;
    else                                   pick_ex = SEL_RF;
  endfunction

  assign ex_fwd_a = pick_ex(ex_use_rs, ex_rs, mem_alu_ok, mem_rd, wb_ok, wb_rd);
  assign ex_fwd_b = pick_ex(ex_use_rt, ex_rt, mem_alu_ok, mem_rd, wb_ok, wb_rd);

  assign id_fwd_a = id_use_rs && mem_alu_ok && (mem_rd == id_rs);
  assign id_fwd_b = id_use_rt && mem_alu_ok && (mem_rd == id_rt);

  logic ex_hit_a, ex_hit_b, ml_hit_a, ml_hit_b, load_use, br_wait;
  assign ex_hit_a = id_use_rs && ex_wr_ok && (ex_rd == id_rs);
  assign ex_hit_b = id_use_rt && ex_wr_ok && (ex_rd == id_rt);
  assign ml_hit_a = id_use_rs && mem_ld_ok && (mem_rd == id_rs);
  assign ml_hit_b = id_use_rt && mem_ld_ok && (mem_rd == id_rt);

  assign load_use = ex_load && (ex_hit_a || ex_hit_b);
  assign br_wait  = id_branch && (ex_hit_a || ex_hit_b || ml_hit_a || ml_hit_b);
  assign stall    = load_use || br_wait;
  assign bubble   = stall;

  logic [DW-1:0] cmp_a, cmp_b;
  assign cmp_a    = id_fwd_a ? mem_alu_data : id_rs_data;
  assign cmp_b    = id_fwd_b ? mem_alu_data : id_rt_data;
  assign br_taken = id_branch && !stall && ((cmp_a == cmp_b) ^ id_branch_ne);

  AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n) (ex_fwd_a != 2'b11) && (ex_fwd_b != 2'b11)); // R3
  AST_MEM_PRIO: assert property (@(posedge clk) disable iff (!rst_n) (ex_use_rs && mem_alu_ok && wb_ok && mem_rd == ex_rs && wb_rd == ex_rs) |-> ex_fwd_a == SEL_MEM); // R4
  AST_ZERO_FWD: assert property (@(posedge clk) disable iff (!rst_n) (ex_rs == '0 && ex_rt == '0) |-> (ex_fwd_a == SEL_RF && ex_fwd_b == SEL_RF)); // R5
  AST_ZERO_STALL: assert property (@(posedge clk) disable iff (!rst_n) (id_rs == '0 && id_rt == '0) |-> !stall); // R5
  AST_LOAD_ONE: assert property (@(posedge clk) disable iff (!rst_n) (stall && ex_load && !id_branch) |=> !stall); // R6
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n) br_taken |-> (!bubble && id_branch)); // R10
  AST_WB_NO_IDFWD: assert property (@(posedge clk) disable iff (!rst_n) (id_use_rs && wb_ok && wb_rd == id_rs && !(mem_we && mem_rd == id_rs)) |-> !id_fwd_a); // R12

endmodule

// File: tb/pipe_hazard_ctl_bench.sv
module pipe_hazard_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 32;

  typedef struct packed {
    logic [4:0] rd, rs, rt;
    logic urs, urt, we, ld, br, bne;
    logic [7:0] tag;
  } ins_t;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  ins_t prog [16];
  int plen = 0;
  int pc;
  ins_t if_id, id_ex, ex_mem, mem_wb;
  logic [DW-1:0] rfv [32];
  logic [DW-1:0] memv;

  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic id_fwd_a, id_fwd_b, stall, bubble, br_taken;

  int cap_exa [16], cap_exb [16], cap_exc [16], cap_ida [16], cap_idb [16], cap_tk [16];
  int n_stall, n_bub, n_tk_stall;

  function automatic ins_t nop();
    ins_t n = '0;
    n.tag = 8'hFF;
    return n;
  endfunction

  function automatic ins_t mk(int tg, int rd, int rs, int rt, bit urs, bit urt, bit we, bit ld, bit br, bit bne);
    ins_t n;
    n.rd = rd[4:0]; n.rs = rs[4:0]; n.rt = rt[4:0];
    n.urs = urs; n.urt = urt; n.we = we; n.ld = ld; n.br = br; n.bne = bne;
    n.tag = tg[7:0];
    return n;
  endfunction

  function automatic ins_t alu(int tg, int rd, int rs, int rt);
    return mk(tg, rd, rs, rt, 1, 1, 1, 0, 0, 0);
  endfunction
  function automatic ins_t lw(int tg, int rd, int rs);
    return mk(tg, rd, rs, 0, 1, 0, 1, 1, 0, 0);
  endfunction
  function automatic ins_t brn(int tg, int rs, int rt, bit ne);
    return mk(tg, 0, rs, rt, 1, 1, 0, 0, 1, ne);
  endfunction

  pipe_hazard_ctl #(.AW(AW), .DW(DW)) u_pipe_hazard_ctl (
    .clk(clk), .rst_n(rst_n),
    .id_rs(if_id.rs), .id_rt(if_id.rt), .id_use_rs(if_id.urs), .id_use_rt(if_id.urt),
    .id_branch(if_id.br), .id_branch_ne(if_id.bne),
    .id_rs_data(rfv[if_id.rs]), .id_rt_data(rfv[if_id.rt]),
    .ex_rs(id_ex.rs), .ex_rt(id_ex.rt), .ex_use_rs(id_ex.urs), .ex_use_rt(id_ex.urt),
    .ex_rd(id_ex.rd), .ex_we(id_ex.we), .ex_load(id_ex.ld),
    .mem_rd(ex_mem.rd), .mem_we(ex_mem.we), .mem_load(ex_mem.ld), .mem_alu_data(memv),
    .wb_rd(mem_wb.rd), .wb_we(mem_wb.we),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b),
    .stall(stall), .bubble(bubble), .br_taken(br_taken)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      if_id <= nop(); id_ex <= nop(); ex_mem <= nop(); mem_wb <= nop(); pc <= 0;
    end else begin
      mem_wb <= ex_mem;
      ex_mem <= id_ex;
      id_ex  <= bubble ? nop() : if_id;
      if (!stall) begin
        if_id <= (pc < plen) ? prog[pc] : nop();
        pc <= pc + 1;
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      summary();
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = nop();
    for (int i = 0; i < 32; i++) rfv[i] = 32'(100 + i);
    memv = 32'hDEAD;
    plen = 0;
  endtask

  task automatic run(int ncyc);
    rst_n = 0;
    for (int i = 0; i < 16; i++) begin
      cap_exa[i] = -1; cap_exb[i] = -1; cap_exc[i] = -1;
      cap_ida[i] = -1; cap_idb[i] = -1; cap_tk[i] = -1;
    end
    n_stall = 0; n_bub = 0; n_tk_stall = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (stall) n_stall++;
      if (bubble) n_bub++;
      if (stall && br_taken) n_tk_stall++;
      if (id_ex.tag != 8'hFF) begin
        cap_exa[id_ex.tag[3:0]] = int'(ex_fwd_a);
        cap_exb[id_ex.tag[3:0]] = int'(ex_fwd_b);
        cap_exc[id_ex.tag[3:0]] = c;
      end
      if (if_id.tag != 8'hFF && !stall) begin
        cap_ida[if_id.tag[3:0]] = int'(id_fwd_a);
        cap_idb[if_id.tag[3:0]] = int'(id_fwd_b);
        cap_tk[if_id.tag[3:0]]  = int'(br_taken);
      end
    end
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = alu(0, 1, 2, 3); plen = 1;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "idle stall", int'(stall), 0);
    chk("R1", "idle bubble", int'(bubble), 0);
    chk("R1", "idle taken", int'(br_taken), 0);
    chk("R1", "idle selects", int'({ex_fwd_a, ex_fwd_b, id_fwd_a, id_fwd_b}), 0);
  endtask

  task automatic t_alu_fwd();
    clear_prog();
    prog[0] = alu(0, 1, 2, 3);
    prog[1] = alu(1, 1, 4, 5);
    prog[2] = alu(2, 6, 1, 8);
    prog[3] = alu(3, 7, 9, 1);
    prog[4] = alu(4, 10, 6, 7);
    plen = 5;
    run(12);
    chk("R4", "two writers of r1, op A", cap_exa[2], 2);
    chk("R3", "r1 only in writeback, op B", cap_exb[3], 1);
    chk("R3", "no producer, op A of tag3", cap_exa[3], 0);
    chk("R2", "r7 in memory stage, op B", cap_exb[4], 2);
    chk("R3", "r6 in writeback, op A", cap_exa[4], 1);
    chk("R2", "no stalls in ALU chain", n_stall, 0);
  endtask

  task automatic t_zero();
    clear_prog();
    prog[0] = lw(0, 0, 0);
    prog[1] = alu(1, 0, 0, 0);
    prog[2] = alu(2, 3, 0, 0);
    prog[3] = brn(3, 0, 0, 0);
    plen = 4;
    run(12);
    chk("R5", "stalls on r0", n_stall, 0);
    chk("R5", "r0 op A select", cap_exa[2], 0);
    chk("R5", "r0 op B select", cap_exb[2], 0);
  endtask

  task automatic t_load_use();
    clear_prog();
    prog[0] = lw(0, 2, 1);
    prog[1] = alu(1, 3, 2, 4);
    prog[2] = lw(2, 5, 1);
    prog[3] = alu(3, 6, 7, 5);
    plen = 4;
    run(14);
    chk("R6", "total stall cycles", n_stall, 2);
    chk("R6", "bubbles match stalls", n_bub, 2);
    chk("R6", "consumer A from writeback", cap_exa[1], 1);
    chk("R6", "consumer B from writeback", cap_exb[3], 1);
    chk("R6", "one extra cycle to execute", cap_exc[1] - cap_exc[0], 2);
  endtask

  task automatic t_load_gap();
    clear_prog();
    prog[0] = lw(0, 2, 1);
    prog[1] = alu(1, 9, 10, 11);
    prog[2] = alu(2, 3, 2, 2);
    plen = 3;
    run(12);
    chk("R7", "stalls with gap", n_stall, 0);
    chk("R7", "gap consumer A", cap_exa[2], 1);
    chk("R7", "gap consumer B", cap_exb[2], 1);
  endtask

  task automatic t_branch_alu();
    clear_prog();
    prog[0] = alu(0, 1, 5, 6);
    prog[1] = brn(1, 1, 2, 0);
    prog[2] = alu(2, 8, 9, 10);
    plen = 3;
    memv = 32'd7;
    rfv[2] = 32'd7;
    run(12);
    chk("R8", "branch stall after ALU", n_stall, 1);
    chk("R8", "comparator A from memory stage", cap_ida[1], 1);
    chk("R8", "comparator B from register file", cap_idb[1], 0);
    chk("R10", "beq equal taken", cap_tk[1], 1);
    chk("R10", "taken during stall", n_tk_stall, 0);
    chk("R11", "delay slot follows branch", cap_exc[2] - cap_exc[1], 1);
  endtask

  task automatic t_branch_load();
    clear_prog();
    prog[0] = lw(0, 4, 1);
    prog[1] = brn(1, 4, 5, 1);
    prog[2] = alu(2, 8, 9, 10);
    plen = 3;
    rfv[4] = 32'd3;
    rfv[5] = 32'd3;
    run(14);
    chk("R9", "branch stall after load", n_stall, 2);
    chk("R9", "resolved from register file", cap_ida[1], 0);
    chk("R10", "bne equal not taken", cap_tk[1], 0);
    chk("R11", "delay slot after untaken branch", cap_exc[2] - cap_exc[1], 1);
  endtask

  task automatic t_branch_wb();
    clear_prog();
    prog[0] = alu(0, 6, 1, 2);
    prog[1] = alu(1, 20, 1, 2);
    prog[2] = alu(2, 21, 1, 2);
    prog[3] = brn(3, 6, 7, 0);
    prog[4] = brn(4, 1, 2, 1);
    plen = 5;
    memv = 32'd1;
    rfv[6] = 32'd9;
    rfv[7] = 32'd9;
    run(14);
    chk("R12", "stalls with writeback producer", n_stall, 0);
    chk("R12", "comparator A from register file", cap_ida[3], 0);
    chk("R10", "beq via register file taken", cap_tk[3], 1);
    chk("R10", "bne differing taken", cap_tk[4], 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rfv[i] = '0;
    memv = '0;
    if_id = nop(); id_ex = nop(); ex_mem = nop(); mem_wb = nop(); pc = 0;
    t_reset();
    t_alu_fwd();
    t_zero();
    t_load_use();
    t_load_gap();
    t_branch_alu();
    t_branch_load();
    t_branch_wb();
    summary();
  end
endmodule